// File: doc/BRIEF.md
# Multi-Channel Silence Detector

This block watches the linear PCM samples entering four speech encoder channels and decides, for each channel, whether the talker has gone quiet. A sample is quiet when its magnitude does not exceed a programmable 13-bit threshold. A channel is declared silent once its quiet samples have run on without a break for longer than a hold time. The hold time is given as a 6-bit count of 8 ms steps, and at 8 kHz sampling one step is 64 samples.

Each channel has its own enable and its own bypass input. Bypass is raised while the channel passes data straight through or loops it back. A channel is watched only while it is enabled and not bypassed. The per-channel silent flags are outputs only. An active-low request line goes low while any flag is set, so a controller can poll for the channel that went quiet.

Top module: `silence_watch`

## Requirements
- R1: After reset every silent flag is 0 and `req_n` is 1.
- R2: A sample is quiet when its magnitude is at most `quiet_level`. The sample is 13-bit two's complement. The comparison is inclusive at both signs, and -4096 has a magnitude of 4096.
- R3: A watched channel raises its flag on the clock edge that accepts its (`hold_steps` × 64 + 1)-th consecutive quiet sample. With `hold_steps` = 0, one quiet sample is enough.
- R4: A valid sample that is not quiet, on a watched channel, clears that channel's run count and flag on the same edge.
- R5: While `det_en` of a channel is 0, its run count and flag are held at 0 and its samples have no effect.
- R6: While `bypass` of a channel is 1, its run count and flag are held at 0 and its samples have no effect.
- R7: A cycle without `smp_valid` for a channel leaves that channel's run count and flag unchanged.
- R8: Channels are independent. Samples, enables and bypasses of one channel never change another channel's flag.
- R9: `req_n` is 0 in every cycle where at least one flag is 1, and 1 when all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 4 | Per-channel sample strobe |
| smp_data | input | 52 | Four 13-bit signed samples; channel k in bits [13k+12:13k] |
| det_en | input | 4 | Per-channel detection enable |
| bypass | input | 4 | Per-channel through/loopback indication; skips detection |
| quiet_level | input | 13 | Magnitude threshold, unsigned |
| hold_steps | input | 6 | Hold time in units of 64 samples |
| silent_flag | output | 4 | Per-channel silent flag |
| req_n | output | 1 | Active-low summary request |

## Verification
The case hardest to reach is the edge of the longest hold window. At `hold_steps` = 63 the flag must stay low through 4032 quiet samples and rise only on sample 4033. One loud sample anywhere in that run must restart the count. The bench holds one channel quiet for the whole window while the other channels get loud samples and gaps. It also runs short windows with gaps between valid strobes. After every sample it compares all flags against a count it keeps itself, so an off-by-one at either end of the run is visible.

// File: rtl/silence_pkg.sv
// Package: shared types and default sizes for the silence detector.
// Assumes 8 kHz sampling, so one 8 ms hold step spans 64 samples.
package silence_pkg;
    localparam int SAMPLE_W_DEF   = 13;
    localparam int TIME_W_DEF     = 6;
    localparam int STEP_SHIFT_DEF = 6;   // log2(64 samples per step)

    // Operating state of one channel's detector
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,   // detection disabled
        CH_WATCH = 2'd1,   // counting quiet samples
        CH_SKIP  = 2'd2    // through/loopback path, detection skipped
    } ch_mode_e;
endpackage

// File: rtl/sw_mag_compare.sv
// Module: sw_mag_compare
// Takes the magnitude of a two's complement sample and compares it with an
// unsigned threshold of the same width. The result is purely combinational.
// Assumes the most negative code has magnitude 2^(W-1), which fits unsigned in W bits.
module sw_mag_compare #(
    parameter int SAMPLE_W = 13
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] level,
    output logic                quiet
);
    logic [SAMPLE_W-1:0] mag;

    // Magnitude of the sample and the inclusive threshold test
    always_comb begin
        mag   = sample[SAMPLE_W-1] ? (~sample + 1'b1) : sample;
        quiet = (mag <= level);
    end
endmodule

// File: rtl/sw_quiet_timer.sv
// Module: sw_quiet_timer
// Counts the consecutive quiet samples of one channel and raises the flag
// once the run is longer than hold * 2^STEP_SHIFT samples.
// Assumes 'quiet' belongs to the sample that is valid in the same cycle.
module sw_quiet_timer
    import silence_pkg::*;
#(
    parameter int TIME_W     = TIME_W_DEF,
    parameter int STEP_SHIFT = STEP_SHIFT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              skip,
    input  logic              valid,
    input  logic              quiet,
    input  logic [TIME_W-1:0] hold,
    output logic              flag
);
    localparam int CNT_W = TIME_W + STEP_SHIFT + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    ch_mode_e         mode;
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] run_inc;
    logic [CNT_W-1:0] limit;

    // Select the operating mode; skip takes precedence over watching
    always_comb begin
        if (!enable)   mode = CH_IDLE;
        else if (skip) mode = CH_SKIP;
        else           mode = CH_WATCH;
    end

    // Hold window in samples and the saturating next count
    always_comb begin
        limit   = {1'b0, hold, {STEP_SHIFT{1'b0}}};
        run_inc = (run_cnt == CNT_MAX) ? run_cnt : run_cnt + 1'b1;
    end

    // Run counter and silent flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            flag    <= 1'b0;
        end else begin
            case (mode)
                CH_WATCH: begin
                    if (valid) begin
                        if (quiet) begin
                            run_cnt <= run_inc;
                            flag    <= (run_inc > limit);
                        end else begin
                            run_cnt <= '0;
                            flag    <= 1'b0;
                        end
                    end
                end
                default: begin
                    run_cnt <= '0;
                    flag    <= 1'b0;
                end
            endcase
        end
    end

    AST_FLAG_RISE_ON_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(valid && quiet && mode == CH_WATCH)); // R3
    AST_LOUD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CH_WATCH && valid && !quiet) |=> (!flag && run_cnt == '0)); // R4
    AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> (!flag && run_cnt == '0)); // R5
    AST_SKIP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && skip) |=> (!flag && run_cnt == '0)); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CH_WATCH && !valid) |=> ($stable(flag) && $stable(run_cnt))); // R7
endmodule

// File: rtl/sw_request_merge.sv
// Module: sw_request_merge
// Combines the per-channel flags into one active-low request line.
// Assumes the flags are registered, so the output is free of glitches between edges.
module sw_request_merge #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] flags,
    output logic              req_n
);
    // Low while any channel reports silence
    always_comb req_n = ~(|flags);
endmodule

// File: rtl/silence_watch.sv
// Module: silence_watch (top)
// Multi-channel silence detector. Each channel has a magnitude comparator
// and a quiet-run timer; the flags are merged into an active-low request.
// Assumes one sample per channel per valid strobe and samples packed per channel.
module silence_watch
    import silence_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int SAMPLE_W   = SAMPLE_W_DEF,
    parameter int TIME_W     = TIME_W_DEF,
    parameter int STEP_SHIFT = STEP_SHIFT_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          smp_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
    input  logic [NUM_CH-1:0]          det_en,
    input  logic [NUM_CH-1:0]          bypass,
    input  logic [SAMPLE_W-1:0]        quiet_level,
    input  logic [TIME_W-1:0]          hold_steps,
    output logic [NUM_CH-1:0]          silent_flag,
    output logic                       req_n
);
    logic [NUM_CH-1:0] quiet_vec;

    // One comparator and one timer per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        sw_mag_compare #(.SAMPLE_W(SAMPLE_W)) u_cmp (
            .sample (smp_data[ch*SAMPLE_W +: SAMPLE_W]),
            .level  (quiet_level),
            .quiet  (quiet_vec[ch])
        );

        sw_quiet_timer #(.TIME_W(TIME_W), .STEP_SHIFT(STEP_SHIFT)) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (det_en[ch]),
            .skip   (bypass[ch]),
            .valid  (smp_valid[ch]),
            .quiet  (quiet_vec[ch]),
            .hold   (hold_steps),
            .flag   (silent_flag[ch])
        );
    end

    sw_request_merge #(.NUM_CH(NUM_CH)) u_merge (
        .flags (silent_flag),
        .req_n (req_n)
    );

    AST_REQ_NEEDS_WATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n) |-> (|($past(det_en) & ~$past(bypass)))); // R9
    AST_RESET_STATE: assert property (@(posedge clk)
        $past(!rst_n) |-> (silent_flag == '0 && req_n)); // R1
endmodule

// File: tb/silence_watch_bench.sv
// Bench: near-exhaustive sweeps of threshold and hold windows, with a
// count model kept in the bench from the requirements.
module silence_watch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int SW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NCH-1:0] tb_valid = '0;
    logic [NCH-1:0] tb_en = '0;
    logic [NCH-1:0] tb_byp = '0;
    logic [SW-1:0]  tb_level = '0;
    logic [5:0]     tb_hold = '0;
    logic [NCH*SW-1:0] tb_data;
    logic [NCH-1:0] flags;
    logic           req_n;
    int             smp [NCH];
    int             m_cnt [NCH];
    bit             m_flag [NCH];
    int             n_tests = 0;
    int             n_fail = 0;
    bit             done = 0;
    string          tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb
        for (int c = 0; c < NCH; c++) tb_data[c*SW +: SW] = SW'(smp[c]);

    silence_watch u_silence_watch (
        .clk(clk), .rst_n(rst_n), .smp_valid(tb_valid), .smp_data(tb_data),
        .det_en(tb_en), .bypass(tb_byp), .quiet_level(tb_level),
        .hold_steps(tb_hold), .silent_flag(flags), .req_n(req_n)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
        end
    endtask

    // Compare every flag with the model and req_n with the flags (R9)
    task automatic compare_all();
        bit any;
        any = 0;
        for (int c = 0; c < NCH; c++) begin
            check(flags[c] == m_flag[c], tag, int'(flags[c]), int'(m_flag[c]));
            any |= m_flag[c];
        end
        check(req_n == !any, "R9", int'(req_n), int'(!any));
    endtask

    // One clock with the given valid mask; model follows R2..R8
    task automatic step(input logic [NCH-1:0] vmask);
        tb_valid = vmask;
        @(posedge clk);
        for (int c = 0; c < NCH; c++) begin
            int a;
            a = (smp[c] < 0) ? -smp[c] : smp[c];
            if (!tb_en[c] || tb_byp[c]) begin
                m_cnt[c] = 0; m_flag[c] = 0;
            end else if (vmask[c]) begin
                if (a <= int'(tb_level)) begin
                    if (m_cnt[c] < 8191) m_cnt[c]++;
                    m_flag[c] = m_cnt[c] > int'(tb_hold) * 64;
                end else begin
                    m_cnt[c] = 0; m_flag[c] = 0;
                end
            end
        end
        @(negedge clk);
        tb_valid = '0;
        compare_all();
    endtask

    task automatic set_all(input int v);
        for (int c = 0; c < NCH; c++) smp[c] = v;
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin smp[c] = 0; m_cnt[c] = 0; m_flag[c] = 0; end
        repeat (3) @(negedge clk);
        tag = "R1";
        compare_all();
        check(flags == '0, "R1", int'(flags), 0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        // R2: threshold sweep around several levels, hold 0, one sample decides
        tag = "R2";
        tb_en = '1;
        tb_hold = 6'd0;
        foreach (smp[i]) smp[i] = 0;
        for (int li = 0; li < 5; li++) begin
            int lv;
            lv = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 5 : (li == 3) ? 100 : 4095;
            tb_level = SW'(lv);
            for (int sg = -1; sg <= 1; sg += 2)
                for (int d = -3; d <= 3; d++) begin
                    for (int c = 0; c < NCH; c++) begin
                        int v;
                        v = sg * lv + d - c;
                        if (v > 4095) v = 4095;
                        if (v < -4096) v = -4096;
                        smp[c] = v;
                    end
                    step('1);
                end
        end
        tb_level = 13'd4095; set_all(-4096); step('1);   // magnitude 4096: loud
        check(flags == '0, "R2", int'(flags), 0);
        tb_level = 13'd4096; set_all(-4096); step('1);   // now quiet
        check(flags == '1, "R2", int'(flags), 15);

        // R3: boundary of several hold windows on all channels
        tag = "R3";
        tb_level = 13'd50;
        for (int hi = 0; hi < 4; hi++) begin
            tb_hold = 6'((hi == 3) ? 5 : hi);
            set_all(900); step('1);
            set_all(-50);
            for (int k = 0; k < int'(tb_hold) * 64 + 3; k++) step('1);
        end

        // R4 and R8: loud sample on channel 1 only
        tag = "R4";
        tb_hold = 6'd0;
        set_all(10); step('1);
        smp[1] = 51; step('1);
        check(flags == 4'b1101, "R8", int'(flags), 13);

        // R7: gaps between valid samples, plus per-channel masks (R8)
        tag = "R7";
        tb_hold = 6'd1;
        set_all(3); step('1);
        set_all(-900); step('1);
        set_all(3);
        for (int k = 0; k < 200; k++) step(4'(k % 16));
        tag = "R8";
        for (int k = 0; k < 160; k++) begin
            smp[3] = (k % 70 == 69) ? 999 : 7;
            step(4'b1011);
        end

        // R5: disable channel 2 while quiet samples keep coming
        tag = "R5";
        tb_en[2] = 1'b0;
        for (int k = 0; k < 80; k++) step('1);
        check(flags[2] == 1'b0, "R5", int'(flags[2]), 0);
        tb_en[2] = 1'b1;
        for (int k = 0; k < 70; k++) step('1);

        // R6: bypass channel 0
        tag = "R6";
        tb_byp[0] = 1'b1;
        for (int k = 0; k < 80; k++) step('1);
        check(flags[0] == 1'b0, "R6", int'(flags[0]), 0);
        tb_byp[0] = 1'b0;
        for (int k = 0; k < 70; k++) step('1);

        // R3: longest window on channel 3, others kept loud
        tag = "R3";
        tb_hold = 6'd63;
        set_all(2000); step('1);
        smp[3] = -12;
        for (int k = 0; k < 4034; k++) step('1);
        check(flags == 4'b1000, "R3", int'(flags), 8);

        // R9: all flags low again
        tag = "R9";
        smp[3] = 3000; step('1);
        check(req_n == 1'b1, "R9", int'(req_n), 1);

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule